// File: doc/BRIEF.md
# Physical Address Decoder with Shadow Control

This block steers every physical memory request to one of three destinations. The boot ROM sits at the very top of a 32-bit address space. System RAM grows upward from address zero. Everything in between falls to an unmapped target. A 64 KiB legacy window just below the 1 MiB line can be laid over RAM. While the window is on, reads in it always reach the RAM copy. Writes in it can be blocked, so that firmware copied there acts as read-only.

The decode is purely combinational: a request shown on one cycle gets its select and its drop flag in that same cycle. The memory map is held in three small configuration registers, written through a simple write port. The first register holds the ROM size in bytes, the second holds the RAM top, and the third holds the window control bits. A downstream fabric forwards a request to the selected target only when the drop flag is low. The unmapped target answers reads with all-ones.

Top module: `paddr_router`

## Requirements
- R1: For each cycle with `req_valid` high, exactly one of `sel_ram`, `sel_rom`, `sel_unmapped` is high, in that same cycle. With `req_valid` low, all selects, `in_shadow` and `wr_drop` are low.
- R2: The ROM occupies addresses from 2^32 minus the ROM size up to 0xFFFFFFFF. The ROM size out of reset is 2 MiB, which places the ROM at 0xFFE00000 through 0xFFFFFFFF. The ROM takes priority over every other region.
- R3: A configuration write with `cfg_idx` = 0 sets the ROM size to `cfg_wdata`, taken as a byte count. The write is accepted only if the value is a power of two from 0x10000 (64 KiB) to 0x1000000 (16 MiB). Any other value leaves the ROM size unchanged.
- R4: A configuration write with `cfg_idx` = 1 sets the RAM top to `cfg_wdata[15:0]`, counted in 64 KiB units. RAM covers addresses from 0 up to, but not including, top × 0x10000. The RAM top is 0 out of reset. With the window off and a top of 0x8000, RAM covers 0x00000000 through 0x7FFFFFFF without a gap.
- R5: A configuration write with `cfg_idx` = 2 sets the window-enable bit from `cfg_wdata[1]` and the shadow-write-enable bit from `cfg_wdata[0]`. While window-enable is 1, any request in 0x000F0000 to 0x000FFFFF raises `in_shadow` and selects RAM, whatever the RAM top. While window-enable is 0, `in_shadow` stays low and those addresses decode by the RAM top.
- R6: A write in the active window raises `wr_drop` when shadow-write-enable is 0. The same write is forwarded to RAM (`wr_drop` low) when shadow-write-enable is 1.
- R7: Out of reset, the window is enabled and shadow-write-enable is 0, so the window is write-protected.
- R8: Addresses at or above the RAM top and below the ROM base, outside an active window, select the unmapped target. Writes there raise `wr_drop`.
- R9: Every write that selects the ROM raises `wr_drop`. A read never raises `wr_drop`.
- R10: A configuration write with `cfg_idx` = 3 changes nothing.
- R11: A configuration write takes effect at the clock edge that captures it. A request in the same cycle as that write is decoded with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Physical byte address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Configuration register index (0 ROM size, 1 RAM top, 2 window control, 3 none) |
| cfg_wdata | input | 32 | Configuration write data |
| sel_ram | output | 1 | Request goes to RAM |
| sel_rom | output | 1 | Request goes to the boot ROM |
| sel_unmapped | output | 1 | Request goes to the unmapped target |
| in_shadow | output | 1 | Request hit the active legacy window |
| wr_drop | output | 1 | Write must be discarded, not forwarded |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 64 KiB RAM granularity, a 64 KiB window ending at 0x000FFFFF, and ROM sizes from 64 KiB to 16 MiB. With these values, every ROM base from 0xFF000000 to 0xFFFF0000 is reachable. So are the 2 GiB contiguous RAM map, the window's edges at 0x000EFFFF, 0x000F0000, 0x000FFFFF and 0x00100000, and a RAM top that runs into the ROM. Random configuration writes include sizes that are not powers of two and sizes outside the legal range. This shows the ROM size register holding its value under illegal input.

// File: rtl/paddr_pkg.sv
package paddr_pkg;

  typedef enum logic [1:0] {
    CFG_ROM_SIZE = 2'd0,
    CFG_RAM_TOP  = 2'd1,
    CFG_WINDOW   = 2'd2,
    CFG_NONE     = 2'd3
  } cfg_idx_e;

  typedef struct packed {
    logic ram;
    logic rom;
    logic hole;
    logic shadow;
    logic drop;
  } route_t;

  // Position of the single set bit of a 32-bit value (0 when none).
  function automatic logic [5:0] bit_index(input logic [31:0] v);
    logic [5:0] idx;
    idx = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) idx = 6'(i);
    end
    return idx;
  endfunction

  // True when v is a power of two with exponent in [lo, hi].
  function automatic logic size_legal(input logic [31:0] v,
                                      input int lo, input int hi);
    logic [5:0] e;
    e = bit_index(v);
    return ($countones(v) == 1) && (int'(e) >= lo) && (int'(e) <= hi);
  endfunction

endpackage

// File: rtl/paddr_cfg.sv
module paddr_cfg
  import paddr_pkg::*;
#(
  parameter int TOP_W        = 16,
  parameter int LOG_W        = 6,
  parameter int ROM_MIN_LOG2 = 16,
  parameter int ROM_MAX_LOG2 = 24,
  parameter int RST_ROM_LOG2 = 21,
  parameter int RST_RAM_TOP  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic [LOG_W-1:0]  rom_log2,
  output logic [TOP_W-1:0]  ram_top,
  output logic              shadow_wr_en,
  output logic              window_en,
  output logic              rom_size_ok
);

  cfg_idx_e idx;
  assign idx = cfg_idx_e'(cfg_idx);

  assign rom_size_ok = size_legal(cfg_wdata, ROM_MIN_LOG2, ROM_MAX_LOG2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_log2     <= LOG_W'(RST_ROM_LOG2);
      ram_top      <= TOP_W'(RST_RAM_TOP);
      shadow_wr_en <= 1'b0;
      window_en    <= 1'b1;
    end else if (cfg_we) begin
      case (idx)
        CFG_ROM_SIZE: if (rom_size_ok) rom_log2 <= LOG_W'(bit_index(cfg_wdata));
        CFG_RAM_TOP:  ram_top <= cfg_wdata[TOP_W-1:0];
        CFG_WINDOW: begin
          shadow_wr_en <= cfg_wdata[0];
          window_en    <= cfg_wdata[1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/paddr_decode.sv
module paddr_decode
  import paddr_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          GRAN_LOG2 = 16,
  parameter int          LOG_W     = 6,
  parameter int          WIN_LOG2  = 16,
  parameter logic [31:0] WIN_END   = 32'h000F_FFFF,
  localparam int         TOP_W     = ADDR_W - GRAN_LOG2,
  localparam int         WTAG_W    = ADDR_W - WIN_LOG2
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LOG_W-1:0]  rom_log2,
  input  logic [TOP_W-1:0]  ram_top,
  input  logic              shadow_wr_en,
  input  logic              window_en,
  output logic              rom_hit,
  output logic              win_hit,
  output logic              ram_hit,
  output route_t            route
);

  localparam logic [WTAG_W-1:0] WIN_TAG = WTAG_W'(WIN_END >> WIN_LOG2);

  logic [ADDR_W-1:0] low_mask;
  logic              below_top;

  always_comb begin
    low_mask  = (ADDR_W'(1) << rom_log2) - ADDR_W'(1);
    rom_hit   = &(req_addr | low_mask);
    win_hit   = window_en && (req_addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
    below_top = req_addr[ADDR_W-1:GRAN_LOG2] < ram_top;
    ram_hit   = !rom_hit && (win_hit || below_top);
  end

  always_comb begin
    route        = '0;
    route.rom    = req_valid && rom_hit;
    route.ram    = req_valid && ram_hit;
    route.hole   = req_valid && !rom_hit && !ram_hit;
    route.shadow = req_valid && win_hit && !rom_hit;
    route.drop   = req_valid && req_write &&
                   (route.rom || route.hole || (route.shadow && !shadow_wr_en));
  end

endmodule

// File: rtl/paddr_router.sv
module paddr_router
  import paddr_pkg::*;
#(
  parameter int          ADDR_W       = 32,
  parameter int          GRAN_LOG2    = 16,
  parameter int          ROM_MIN_LOG2 = 16,
  parameter int          ROM_MAX_LOG2 = 24,
  parameter int          RST_ROM_LOG2 = 21,
  parameter int          WIN_LOG2     = 16,
  parameter logic [31:0] WIN_END      = 32'h000F_FFFF,
  localparam int         TOP_W        = ADDR_W - GRAN_LOG2,
  localparam int         LOG_W        = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic              sel_ram,
  output logic              sel_rom,
  output logic              sel_unmapped,
  output logic              in_shadow,
  output logic              wr_drop
);

  logic [LOG_W-1:0] rom_log2_w;
  logic [TOP_W-1:0] ram_top_w;
  logic             shadow_wr_en_w;
  logic             window_en_w;
  logic             rom_size_ok_w;
  logic             rom_hit_w;
  logic             win_hit_w;
  logic             ram_hit_w;
  route_t           route_w;

  paddr_cfg #(
    .TOP_W        (TOP_W),
    .LOG_W        (LOG_W),
    .ROM_MIN_LOG2 (ROM_MIN_LOG2),
    .ROM_MAX_LOG2 (ROM_MAX_LOG2),
    .RST_ROM_LOG2 (RST_ROM_LOG2),
    .RST_RAM_TOP  (0)
  ) cfg_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_wdata    (cfg_wdata),
    .rom_log2     (rom_log2_w),
    .ram_top      (ram_top_w),
    .shadow_wr_en (shadow_wr_en_w),
    .window_en    (window_en_w),
    .rom_size_ok  (rom_size_ok_w)
  );

  paddr_decode #(
    .ADDR_W    (ADDR_W),
    .GRAN_LOG2 (GRAN_LOG2),
    .LOG_W     (LOG_W),
    .WIN_LOG2  (WIN_LOG2),
    .WIN_END   (WIN_END)
  ) dec_i (
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .rom_log2     (rom_log2_w),
    .ram_top      (ram_top_w),
    .shadow_wr_en (shadow_wr_en_w),
    .window_en    (window_en_w),
    .rom_hit      (rom_hit_w),
    .win_hit      (win_hit_w),
    .ram_hit      (ram_hit_w),
    .route        (route_w)
  );

  assign sel_ram      = route_w.ram;
  assign sel_rom      = route_w.rom;
  assign sel_unmapped = route_w.hole;
  assign in_shadow    = route_w.shadow;
  assign wr_drop      = route_w.drop;

endmodule

// File: rtl/paddr_router_chk.sv
module paddr_router_chk #(
  parameter int LOG_W        = 6,
  parameter int ROM_MIN_LOG2 = 16,
  parameter int ROM_MAX_LOG2 = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             cfg_we,
  input logic [1:0]       cfg_idx,
  input logic             sel_ram,
  input logic             sel_rom,
  input logic             sel_unmapped,
  input logic             in_shadow,
  input logic             wr_drop,
  input logic [LOG_W-1:0] rom_log2_w,
  input logic             rom_size_ok_w,
  input logic             shadow_wr_en_w,
  input logic             window_en_w
);

  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones({sel_ram, sel_rom, sel_unmapped}) == 1);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(sel_ram || sel_rom || sel_unmapped || in_shadow || wr_drop));

  assert_rom_log2_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rom_log2_w) >= ROM_MIN_LOG2) && (int'(rom_log2_w) <= ROM_MAX_LOG2));

  assert_rom_size_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_idx == 2'd0 && !rom_size_ok_w) |=> $stable(rom_log2_w));

  assert_shadow_to_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_shadow |-> sel_ram);

  assert_shadow_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && in_shadow && !shadow_wr_en_w) |-> wr_drop);

  assert_reset_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (window_en_w && !shadow_wr_en_w));

  assert_hole_wr_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && sel_unmapped) |-> wr_drop);

  assert_rom_wr_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && sel_rom) |-> wr_drop);

  assert_read_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |-> !wr_drop);

endmodule

bind paddr_router paddr_router_chk #(
  .LOG_W        (LOG_W),
  .ROM_MIN_LOG2 (ROM_MIN_LOG2),
  .ROM_MAX_LOG2 (ROM_MAX_LOG2)
) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_write      (req_write),
  .cfg_we         (cfg_we),
  .cfg_idx        (cfg_idx),
  .sel_ram        (sel_ram),
  .sel_rom        (sel_rom),
  .sel_unmapped   (sel_unmapped),
  .in_shadow      (in_shadow),
  .wr_drop        (wr_drop),
  .rom_log2_w     (rom_log2_w),
  .rom_size_ok_w  (rom_size_ok_w),
  .shadow_wr_en_w (shadow_wr_en_w),
  .window_en_w    (window_en_w)
);

// File: tb/paddr_router_tb_top.sv
module paddr_router_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sel_ram, sel_rom, sel_unmapped, in_shadow, wr_drop;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench-side model of the configuration.
  int          m_size = 32'h0020_0000;
  int unsigned m_top  = 0;
  bit          m_wen  = 0;
  bit          m_win  = 1;

  always #5 clk = ~clk;

  paddr_router dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .sel_ram(sel_ram), .sel_rom(sel_rom), .sel_unmapped(sel_unmapped),
    .in_shadow(in_shadow), .wr_drop(wr_drop)
  );

  // Expected {ram, rom, unmapped, shadow, drop} from the requirements.
  function automatic logic [4:0] expect_route(input logic [31:0] a, input bit wr);
    longint unsigned ua, rom_base, ram_end;
    bit rom, win, ram, hole, drop;
    ua       = longint'(a);
    rom_base = 64'h1_0000_0000 - longint'(unsigned'(m_size));
    ram_end  = longint'(m_top) * 64'h1_0000;
    rom  = ua >= rom_base;
    win  = m_win && a >= 32'h000F_0000 && a <= 32'h000F_FFFF;
    ram  = !rom && (win || ua < ram_end);
    hole = !rom && !ram;
    drop = wr && (rom || hole || (win && !m_wen));
    return {ram, rom, hole, win && !rom, drop};
  endfunction

  function automatic string region_tag(input logic [4:0] e);
    if (e[3]) return "R2";
    if (e[1]) return "R5";
    if (e[4]) return "R4";
    return "R8";
  endfunction

  task automatic compare(input string tag, input logic [4:0] exp_v);
    logic [4:0] act;
    act = {sel_ram, sel_rom, sel_unmapped, in_shadow, wr_drop};
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s addr=%h wr=%0b actual=%b expected=%b", tag, req_addr,
               req_write, act, exp_v);
    end
  endtask

  task automatic do_req(input logic [31:0] a, input bit wr, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    #1;
    compare(tag, expect_route(a, wr));
    req_valid = 1'b0;
  endtask

  function automatic void model_cfg(input logic [1:0] idx, input logic [31:0] d);
    case (idx)
      2'd0: if ($countones(d) == 1 && d >= 32'h1_0000 && d <= 32'h100_0000) m_size = int'(d);
      2'd1: m_top = int'(d[15:0]);
      2'd2: begin m_wen = d[0]; m_win = d[1]; end
      default: ;
    endcase
  endfunction

  task automatic cfg_write(input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    model_cfg(idx, d);
  endtask

  function automatic logic [31:0] pick_addr();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 5)
      0: return 32'hFF00_0000 | (r & 32'h00FF_FFFF);
      1: return 32'h000E_8000 + (r % 32'h0002_0000);
      2: return (m_top * 32'h1_0000) - 32'h40 + (r % 32'h80);
      3: return 32'h1_0000 * ($urandom % 8);
      default: return r;
    endcase
  endfunction

  function automatic logic [31:0] pick_cfg(input logic [1:0] idx);
    case (idx)
      2'd0: return ($urandom % 4 == 0) ? $urandom : (32'h1 << (14 + $urandom % 13));
      2'd1: return ($urandom % 2) ? 32'h0000_8000 : $urandom;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: idle means quiet outputs
    #1 compare("R1 idle", 5'b00000);

    // R2 / R7 reset map
    do_req(32'hFFE0_0000, 0, "R2 rom base 2MiB");
    do_req(32'hFFDF_FFFF, 0, "R2 below rom");
    do_req(32'hFFFF_FFF0, 1, "R9 rom write");
    do_req(32'h000F_0000, 1, "R7 window protected");
    do_req(32'h000F_FFFF, 0, "R7 window read");
    do_req(32'h0000_0000, 0, "R4 no ram at reset");

    // R3: illegal sizes ignored
    cfg_write(2'd0, 32'h0003_0000);
    do_req(32'hFFE0_0000, 0, "R3 non-pow2 ignored");
    cfg_write(2'd0, 32'h0000_8000);
    do_req(32'hFFDF_0000, 0, "R3 too small ignored");
    cfg_write(2'd0, 32'h0200_0000);
    do_req(32'hFF00_0000, 0, "R3 too large ignored");
    cfg_write(2'd0, 32'h0100_0000);
    do_req(32'hFF00_0000, 0, "R3 16MiB accepted");
    do_req(32'hFEFF_FFFF, 1, "R8 just below rom");
    cfg_write(2'd0, 32'h0001_0000);
    do_req(32'hFFFF_0000, 1, "R3 64KiB rom");
    do_req(32'hFFFE_FFFF, 0, "R3 64KiB edge");

    // R4: 2 GiB contiguous, window off
    cfg_write(2'd1, 32'h0000_8000);
    cfg_write(2'd2, 32'h0000_0000);
    do_req(32'h0000_0000, 1, "R4 ram bottom");
    do_req(32'h7FFF_FFFF, 1, "R4 ram top byte");
    do_req(32'h8000_0000, 0, "R8 above ram");
    do_req(32'h000F_8000, 1, "R5 window off plain ram");

    // R6: window writable vs protected
    cfg_write(2'd2, 32'h0000_0003);
    do_req(32'h000F_1234, 1, "R6 window writable");
    cfg_write(2'd2, 32'h0000_0002);
    do_req(32'h000F_1234, 1, "R6 window protected");
    cfg_write(2'd1, 32'h0000_0000);
    do_req(32'h000F_0000, 0, "R5 window beyond top");
    do_req(32'h000E_FFFF, 0, "R5 below window");
    do_req(32'h0010_0000, 0, "R5 above window");

    // R10: index 3 ignored
    cfg_write(2'd3, 32'hFFFF_FFFF);
    do_req(32'h000F_0000, 1, "R10 reserved index");
    do_req(32'h0000_0000, 0, "R10 reserved index ram");

    // R11: same-cycle request sees old settings
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'd1; cfg_wdata = 32'h0000_0100;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_1000;
    #1 compare("R11 before edge", expect_route(32'h0000_1000, 0));
    @(posedge clk);
    #1 cfg_we = 1'b0;
    model_cfg(2'd1, 32'h0000_0100);
    compare("R11 after edge", expect_route(32'h0000_1000, 0));
    req_valid = 1'b0;

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) begin
        logic [1:0] ci;
        ci = 2'($urandom % 4);
        cfg_write(ci, pick_cfg(ci));
      end
      ra = pick_addr();
      do_req(ra, bit'($urandom % 2), region_tag(expect_route(ra, 0)));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule